// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block maintains the two error counters of a CAN node and derives from them the node's confinement state: error active, error passive or bus off. A protocol engine feeds it one-cycle event pulses: a failed transmission (an acknowledge slot sampled recessive is one such failure), a receive error, a successful transmission and a successful reception. It also feeds a strobe for every sampled bus bit, together with the bit's level.

While the node is passive, the block raises a request that tells the frame-end sequencer to add the eight-bit suspend-transmission period after intermission. The automatic retry of a failed frame stays with the transmitter. The transmitter may keep retrying while the node is not bus off. The block decides when the node must stop transmitting. It also decides when the node may join the bus again: the bus must show 128 runs of 11 consecutive recessive bits.

Top module: `can_fault_tracker`

## Requirements
- R1: After reset both counters read 0, `state_o` reads 2'b00 (active) and `suspend_req_o` is low.
- R2: A `tx_err_i` pulse adds 8 to `tec_o`. Otherwise a `tx_ok_i` pulse subtracts 1, and nothing happens at 0. When both pulses arrive in one cycle, the error wins. The counter saturates at 511.
- R3: A `rx_err_i` pulse adds 1 to `rec_o`. Otherwise a `rx_ok_i` pulse subtracts 1, and nothing happens at 0. The error wins over a simultaneous success. The counter saturates at 511.
- R4: `state_o` encodes 2'b00 active, 2'b01 passive and 2'b10 bus off. The state is passive when either counter is 128 or more and `tec_o` is 255 or less.
- R5: The state is bus off whenever `tec_o` is 256 or more. Starting from zero, 31 transmit errors leave the node passive and the 32nd makes it bus off.
- R6: `suspend_req_o` is high exactly when the state is passive. It is low when the node is active and when it is bus off.
- R7: While the node is bus off, all four error and success pulses are ignored. Both counters hold their values.
- R8: While the node is bus off, each recessive bit (`bit_tick_i` high with `bus_bit_i` = 1) extends the current run. Every 11th consecutive recessive bit completes a run. On the clock edge that completes the 128th run, both counters clear and the state returns to active. Idle cycles without a strobe do not break a run.
- R9: A dominant bit (`bit_tick_i` high with `bus_bit_i` = 0) restarts the current run at zero. Runs already completed are kept.
- R10: After 16 back-to-back transmit failures starting from zero, `tec_o` is 128, the node is passive and the suspend request is high. One success then returns the node to active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err_i | input | 1 | Transmit error event pulse |
| rx_err_i | input | 1 | Receive error event pulse |
| tx_ok_i | input | 1 | Successful transmission pulse |
| rx_ok_i | input | 1 | Successful reception pulse |
| bit_tick_i | input | 1 | Strobe marking one sampled bus bit |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 9 | Receive error counter |
| state_o | output | 2 | Confinement state |
| suspend_req_o | output | 1 | Suspend-transmission request to the frame-end sequencer |

## Verification
The state is decoded directly from the counters. A counter that is off by one step therefore shows on `tec_o` or `rec_o` right after the edge that took the pulse, and the compare of the next cycle catches it. A wrong threshold shows up later, at the 16th or 32nd failure. The recovery counters are hidden, so a fault in them can only appear as a bus-off exit that comes too early or too late. The bench therefore checks the state both one bit before the final recessive bit and on that bit. It also inserts a dominant bit near the end of the sequence, so that a run count cleared by mistake would delay the exit visibly.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'b00,
      FC_PASSIVE = 2'b01,
      FC_BUSOFF  = 2'b10
   } fc_state_e;

endpackage

// File: rtl/can_fc_counter.sv
module can_fc_counter #(
   parameter int W       = 9,
   parameter int UP_STEP = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         hold_i,
   input  logic         inc_i,
   input  logic         dec_i,
   output logic [W-1:0] cnt_o
);
   localparam int           MAX_I = (1 << W) - 1;
   localparam logic [W:0]   MAX_X = (W+1)'(MAX_I);
   localparam logic [W:0]   STEP  = (W+1)'(UP_STEP);

   generate
      if (UP_STEP < 1 || UP_STEP > MAX_I) begin : g_bad_step
         $error("can_fc_counter: UP_STEP out of range");
      end
   endgenerate

   logic [W-1:0] cnt_q;
   logic [W:0]   sum;

   assign sum = {1'b0, cnt_q} + STEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (!hold_i) begin
         if (inc_i) begin
            cnt_q <= (sum > MAX_X) ? MAX_X[W-1:0] : sum[W-1:0];
         end else if (dec_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;

   // R2 R3
   rise_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> int'(cnt_q) <= int'($past(cnt_q)) + UP_STEP);

   // R2 R3
   fall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> int'(cnt_q) + 1 >= int'($past(cnt_q)));

endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
   parameter int RUN_LEN   = 11,
   parameter int RUN_COUNT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic bit_tick_i,
   input  logic bus_bit_i,
   output logic done_o
);
   localparam int RUN_W = $clog2(RUN_LEN);
   localparam int CNT_W = $clog2(RUN_COUNT);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_COUNT - 1);

   generate
      if (RUN_LEN < 2 || RUN_COUNT < 2) begin : g_bad_len
         $error("can_fc_recovery: RUN_LEN and RUN_COUNT must be at least 2");
      end
   endgenerate

   logic [RUN_W-1:0] run_q;
   logic [CNT_W-1:0] runs_q;
   logic             rec_bit;
   logic             run_end;

   assign rec_bit = active_i && bit_tick_i && bus_bit_i;
   assign run_end = rec_bit && run_q == RUN_LAST;
   assign done_o  = run_end && runs_q == CNT_LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         runs_q <= '0;
      end else if (!active_i || done_o) begin
         run_q  <= '0;
         runs_q <= '0;
      end else if (bit_tick_i) begin
         if (!bus_bit_i) begin
            run_q <= '0;
         end else if (run_end) begin
            run_q  <= '0;
            runs_q <= runs_q + 1'b1;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   // R9
   dominant_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && bit_tick_i && !bus_bit_i) |=> (run_q == '0 && runs_q == $past(runs_q)));

   // R8
   run_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && !bit_tick_i) |=> $stable(runs_q));

endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker #(
   parameter int CNT_W         = 9,
   parameter int TX_ERR_STEP   = 8,
   parameter int RX_ERR_STEP   = 1,
   parameter int PASSIVE_LIMIT = 128,
   parameter int BUSOFF_LIMIT  = 256,
   parameter int RUN_LEN       = 11,
   parameter int RUN_COUNT     = 128,
   parameter bit SUSPEND_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_err_i,
   input  logic             rx_err_i,
   input  logic             tx_ok_i,
   input  logic             rx_ok_i,
   input  logic             bit_tick_i,
   input  logic             bus_bit_i,
   output logic [CNT_W-1:0] tec_o,
   output logic [CNT_W-1:0] rec_o,
   output logic [1:0]       state_o,
   output logic             suspend_req_o
);
   import can_fc_pkg::*;

   localparam logic [CNT_W-1:0] PAS_L = CNT_W'(PASSIVE_LIMIT);
   localparam logic [CNT_W-1:0] BO_L  = CNT_W'(BUSOFF_LIMIT);

   generate
      if (BUSOFF_LIMIT >= (1 << CNT_W)) begin : g_bad_bo
         $error("can_fault_tracker: BUSOFF_LIMIT does not fit CNT_W");
      end
      if (PASSIVE_LIMIT < 1 || PASSIVE_LIMIT >= BUSOFF_LIMIT) begin : g_bad_pas
         $error("can_fault_tracker: PASSIVE_LIMIT must lie below BUSOFF_LIMIT");
      end
   endgenerate

   logic [CNT_W-1:0] tec_q;
   logic [CNT_W-1:0] rec_q;
   fc_state_e        fc_state;
   logic             busoff;
   logic             recov_done;

   always_comb begin
      if (tec_q >= BO_L)
         fc_state = FC_BUSOFF;
      else if (tec_q >= PAS_L || rec_q >= PAS_L)
         fc_state = FC_PASSIVE;
      else
         fc_state = FC_ACTIVE;
   end

   assign busoff = (fc_state == FC_BUSOFF);

   can_fc_counter #(.W(CNT_W), .UP_STEP(TX_ERR_STEP)) u_tec (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (recov_done),
      .hold_i (busoff),
      .inc_i  (tx_err_i),
      .dec_i  (tx_ok_i),
      .cnt_o  (tec_q)
   );

   can_fc_counter #(.W(CNT_W), .UP_STEP(RX_ERR_STEP)) u_rec (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (recov_done),
      .hold_i (busoff),
      .inc_i  (rx_err_i),
      .dec_i  (rx_ok_i),
      .cnt_o  (rec_q)
   );

   can_fc_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (busoff),
      .bit_tick_i (bit_tick_i),
      .bus_bit_i  (bus_bit_i),
      .done_o     (recov_done)
   );

   generate
      if (SUSPEND_EN) begin : g_susp
         assign suspend_req_o = (fc_state == FC_PASSIVE);
      end else begin : g_nosusp
         assign suspend_req_o = 1'b0;
      end
   endgenerate

   assign tec_o   = tec_q;
   assign rec_o   = rec_q;
   assign state_o = fc_state;

   // R7
   busoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busoff && !recov_done) |=> ($stable(tec_q) && $stable(rec_q)));

   // R8
   recov_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recov_done |=> (tec_q == '0 && rec_q == '0 && state_o == FC_ACTIVE));

   // R6
   no_suspend_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busoff |-> !suspend_req_o);

   // R5
   busoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busoff && !tx_err_i) |=> !busoff);

endmodule

// File: tb/can_fault_tracker_test.sv
`timescale 1ns/100ps
module can_fault_tracker_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_err = 1'b0, rx_err = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0;
   logic       tick = 1'b0, bus = 1'b1;
   logic [8:0] tec, rec;
   logic [1:0] state;
   logic       susp;

   int n_chk = 0;
   int n_err = 0;
   bit cmp_en = 1'b0;

   int m_tec, m_rec, m_run, m_runs;

   always #2.5 clk = ~clk;

   can_fault_tracker uut (
      .clk(clk), .rst_n(rst_n),
      .tx_err_i(tx_err), .rx_err_i(rx_err), .tx_ok_i(tx_ok), .rx_ok_i(rx_ok),
      .bit_tick_i(tick), .bus_bit_i(bus),
      .tec_o(tec), .rec_o(rec), .state_o(state), .suspend_req_o(susp)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_state();
      if (m_tec >= 256) return 2;
      if (m_tec >= 128 || m_rec >= 128) return 1;
      return 0;
   endfunction

   // behavioural reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tec <= 0; m_rec <= 0; m_run <= 0; m_runs <= 0;
      end else if (m_tec >= 256) begin
         if (tick) begin
            if (bus) begin
               if (m_run == 10) begin
                  m_run <= 0;
                  if (m_runs == 127) begin
                     m_runs <= 0; m_tec <= 0; m_rec <= 0;
                  end else begin
                     m_runs <= m_runs + 1;
                  end
               end else begin
                  m_run <= m_run + 1;
               end
            end else begin
               m_run <= 0;
            end
         end
      end else begin
         m_run <= 0; m_runs <= 0;
         if (tx_err) m_tec <= (m_tec + 8 > 511) ? 511 : m_tec + 8;
         else if (tx_ok && m_tec > 0) m_tec <= m_tec - 1;
         if (rx_err) m_rec <= (m_rec + 1 > 511) ? 511 : m_rec + 1;
         else if (rx_ok && m_rec > 0) m_rec <= m_rec - 1;
      end
   end

   // per-cycle compare, away from both clock edges
   always @(posedge clk) begin
      #1;
      if (cmp_en) begin
         chk("R2 tec model", int'(tec), m_tec);
         chk("R3 rec model", int'(rec), m_rec);
         chk("R4 state model", int'(state), exp_state());
         chk("R6 suspend model", int'(susp), (exp_state() == 1) ? 1 : 0);
      end
   end

   task automatic ev(input logic te, input logic re, input logic to, input logic ro);
      @(negedge clk);
      tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro;
      @(negedge clk);
      tx_err = 1'b0; rx_err = 1'b0; tx_ok = 1'b0; rx_ok = 1'b0;
   endtask

   task automatic bitx(input logic b);
      @(negedge clk);
      tick = 1'b1; bus = b;
      @(negedge clk);
      tick = 1'b0; bus = 1'b1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 tec", int'(tec), 0);
      chk("R1 rec", int'(rec), 0);
      chk("R1 state", int'(state), 0);
      chk("R1 suspend", int'(susp), 0);
      rst_n = 1'b1;
      cmp_en = 1'b1;

      // R2 step up, step down, error wins
      repeat (3) ev(1, 0, 0, 0);
      chk("R2 three errors", int'(tec), 24);
      repeat (5) ev(0, 0, 1, 0);
      chk("R2 five successes", int'(tec), 19);
      ev(1, 0, 1, 0);
      chk("R2 error beats success", int'(tec), 27);
      repeat (30) ev(0, 0, 1, 0);
      chk("R2 floor at zero", int'(tec), 0);

      // R3 receive counter
      repeat (4) ev(0, 1, 0, 0);
      ev(0, 1, 0, 1);
      chk("R3 error beats success", int'(rec), 5);
      repeat (7) ev(0, 0, 0, 1);
      chk("R3 floor at zero", int'(rec), 0);

      // R10 sixteen failed transmissions
      do_reset();
      chk("R1 after re-reset", int'(tec), 0);
      repeat (15) ev(1, 0, 0, 0);
      chk("R10 still active at 120", int'(state), 0);
      ev(1, 0, 0, 0);
      chk("R10 tec at 16 failures", int'(tec), 128);
      chk("R10 passive", int'(state), 1);
      chk("R6 suspend when passive", int'(susp), 1);
      ev(0, 0, 1, 0);
      chk("R10 back to active", int'(state), 0);
      chk("R6 suspend released", int'(susp), 0);

      // R4 passive through receive counter
      do_reset();
      repeat (128) ev(0, 1, 0, 0);
      chk("R4 rec passive", int'(state), 1);
      ev(0, 0, 0, 1);
      chk("R4 rec active again", int'(state), 0);

      // R3 saturation
      do_reset();
      repeat (520) ev(0, 1, 0, 0);
      chk("R3 saturate", int'(rec), 511);
      chk("R4 passive with saturated rec", int'(state), 1);

      // R5 bus-off entry
      do_reset();
      repeat (5) ev(0, 1, 0, 0);
      repeat (31) ev(1, 0, 0, 0);
      chk("R5 passive at 248", int'(state), 1);
      ev(1, 0, 0, 0);
      chk("R5 tec 256", int'(tec), 256);
      chk("R5 busoff", int'(state), 2);
      chk("R6 no suspend in busoff", int'(susp), 0);

      // R7 events ignored
      ev(1, 1, 1, 1);
      ev(0, 0, 1, 1);
      ev(1, 1, 0, 0);
      chk("R7 tec held", int'(tec), 256);
      chk("R7 rec held", int'(rec), 5);
      chk("R7 still busoff", int'(state), 2);

      // R8 and R9 recovery
      for (int r = 0; r < 127; r++) begin
         for (int b = 0; b < 11; b++) bitx(1'b1);
      end
      chk("R8 busoff after 127 runs", int'(state), 2);
      repeat (10) bitx(1'b1);
      bitx(1'b0);
      repeat (10) bitx(1'b1);
      chk("R9 dominant restarted the run", int'(state), 2);
      chk("R9 tec still held", int'(tec), 256);
      bitx(1'b1);
      chk("R8 tec cleared", int'(tec), 0);
      chk("R8 rec cleared", int'(rec), 0);
      chk("R8 active", int'(state), 0);
      ev(1, 0, 0, 0);
      chk("R8 counting resumes", int'(tec), 8);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule